// File: doc/BRIEF.md
# SPI Receive Flag Controller

This block is the receive half of an SPI peripheral as a processor sees it. A mode-0 slave shifter takes bits from the serial pins and builds bytes. It samples on each rising serial clock while the select line is low and takes the most significant bit first. Each finished byte goes to a receive data register and sets a receive-full flag. If a byte finishes while the previous byte is still unread, an overflow flag is set and the new byte is thrown away.

Software clears the flags with two reads in order. First it reads the status register and sees the flag set. Then it reads the data register. While the overflow flag is set, later bytes are lost without setting the receive-full flag. An overflow that arrives between the status read and the data read is therefore easy to miss. It can be caught with a second status read, or reported at once by enabling the error interrupt. The receive interrupt is the receive-full flag gated by its enable. The error interrupt is the overflow flag gated by its enable.

Top module: `spi_rx_flags`

## Requirements
- R1: After reset, both flags, both interrupt enables, the data register and both interrupt outputs are zero.
- R2: When a byte completes (eight rising SCK edges with ss_n low, MSB first) and both flags are clear, the byte appears on dataOut and the receive-full flag (statusOut bit 7) is set.
- R3: The receive-full flag clears only on a data read that follows a status read which saw the flag set. A data read without such a status read leaves it set.
- R4: A byte that completes while the receive-full flag is set sets the overflow flag (statusOut bit 6) and is discarded. dataOut keeps the earlier byte.
- R5: If the overflow flag was clear at the last status read, a data read clears the receive-full flag and leaves the overflow flag set.
- R6: While the overflow flag is set, completed bytes are lost. They neither set the receive-full flag nor change dataOut.
- R7: The overflow flag clears only on a data read that follows a status read which saw it set.
- R8: rxIrq equals the receive-full flag AND the receive interrupt enable.
- R9: errIrq equals the overflow flag AND the error interrupt enable.
- R10: Raising ss_n resets the bit counter, so a partial byte is dropped and the next byte is aligned from its first bit.
- R11: A control write loads ctrlWrData bit 0 into the receive interrupt enable and bit 1 into the error interrupt enable. Both read back on statusOut bits 0 and 1; statusOut bits 5 to 2 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master (asynchronous) |
| mosi | input | 1 | Serial data in (asynchronous) |
| ss_n | input | 1 | Active-low slave select (asynchronous) |
| statusRd | input | 1 | Status register read strobe, one cycle |
| dataRd | input | 1 | Data register read strobe, one cycle |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlWrData | input | 2 | Enables to write: bit 1 error, bit 0 receive |
| statusOut | output | 8 | Status: full, overflow, zeros, error enable, receive enable |
| dataOut | output | 8 | Receive data register |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Error interrupt request |

## Verification
The key case is an overflow that lands between the status read and the data read. A design that armed its clears from current flag values rather than from what the status read saw would wrongly clear the overflow on that data read. A data read with no status read before it must leave both flags alone; a design without the arming step would clear them. Bytes sent during overflow must leave dataOut and the full flag untouched, which exposes a lockout that lets later bytes through. A select pulse in the middle of a byte checks that a stale bit count does not misalign the next byte.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef struct packed {
    logic loadData;
    logic dropByte;
  } rxStrobe_t;
endpackage

// File: rtl/spi_rx_dp.sv
module spi_rx_dp
  import spi_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              ss_n,
  input  logic              ctrlWr,
  input  logic [1:0]        ctrlWrData,
  input  rxStrobe_t         strobe,
  output logic              byteDone,
  output logic [DATA_W-1:0] newByte,
  output logic [DATA_W-1:0] dataReg,
  output logic              rxIe,
  output logic              errIe
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sckSync, mosiSync, ssSync;
  logic sckPrev;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sckSync[s]  <= 1'b0;
          mosiSync[s] <= 1'b0;
          ssSync[s]   <= 1'b1;
        end else if (s == 0) begin
          sckSync[s]  <= sck;
          mosiSync[s] <= mosi;
          ssSync[s]   <= ss_n;
        end else begin
          sckSync[s]  <= sckSync[s-1];
          mosiSync[s] <= mosiSync[s-1];
          ssSync[s]   <= ssSync[s-1];
        end
      end
    end
  endgenerate

  logic sckNow, mosiNow, ssNow, sckRise;
  assign sckNow  = sckSync[SYNC_STAGES-1];
  assign mosiNow = mosiSync[SYNC_STAGES-1];
  assign ssNow   = ssSync[SYNC_STAGES-1];
  assign sckRise = sckNow & ~sckPrev & ~ssNow;

  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg;

  assign newByte  = {shiftReg[DATA_W-2:0], mosiNow};
  assign byteDone = sckRise && (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckPrev  <= 1'b0;
      bitCnt   <= '0;
      shiftReg <= '0;
    end else begin
      sckPrev <= sckNow;
      if (ssNow) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        shiftReg <= newByte;
        bitCnt   <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataReg <= '0;
      rxIe    <= 1'b0;
      errIe   <= 1'b0;
    end else begin
      if (strobe.loadData) dataReg <= newByte;
      if (ctrlWr) begin
        rxIe  <= ctrlWrData[0];
        errIe <= ctrlWrData[1];
      end
    end
  end
endmodule

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
  import spi_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      byteDone,
  input  logic      statusRd,
  input  logic      dataRd,
  output rxStrobe_t strobe,
  output logic      fullFlag,
  output logic      ovfFlag
);
  logic armFull, armOvf;

  always_comb begin
    strobe.loadData = byteDone & ~fullFlag & ~ovfFlag;
    strobe.dropByte = byteDone & (fullFlag | ovfFlag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fullFlag <= 1'b0;
      ovfFlag  <= 1'b0;
      armFull  <= 1'b0;
      armOvf   <= 1'b0;
    end else begin
      if (statusRd) begin
        armFull <= fullFlag;
        armOvf  <= ovfFlag;
      end
      if (dataRd) begin
        if (armFull) fullFlag <= 1'b0;
        if (armOvf)  ovfFlag  <= 1'b0;
        armFull <= 1'b0;
        armOvf  <= 1'b0;
      end
      if (strobe.loadData) fullFlag <= 1'b1;
      if (strobe.dropByte && !ovfFlag) ovfFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags
  import spi_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              ss_n,
  input  logic              statusRd,
  input  logic              dataRd,
  input  logic              ctrlWr,
  input  logic [1:0]        ctrlWrData,
  output logic [7:0]        statusOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              rxIrq,
  output logic              errIrq
);
  rxStrobe_t         strobe;
  logic              byteDone, fullFlag, ovfFlag, rxIe, errIe;
  logic [DATA_W-1:0] newByte;

  spi_rx_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ss_n(ss_n),
    .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData), .strobe(strobe),
    .byteDone(byteDone), .newByte(newByte), .dataReg(dataOut),
    .rxIe(rxIe), .errIe(errIe)
  );

  spi_rx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .byteDone(byteDone), .statusRd(statusRd),
    .dataRd(dataRd), .strobe(strobe), .fullFlag(fullFlag), .ovfFlag(ovfFlag)
  );

  assign statusOut = {fullFlag, ovfFlag, 4'b0000, errIe, rxIe};
  assign rxIrq     = fullFlag & rxIe;
  assign errIrq    = ovfFlag & errIe;
endmodule

// File: rtl/spi_rx_flags_chk.sv
module spi_rx_flags_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              statusRd,
  input logic              dataRd,
  input logic [7:0]        statusOut,
  input logic [DATA_W-1:0] dataOut,
  input logic              rxIrq,
  input logic              errIrq,
  input logic              byteDone,
  input logic [DATA_W-1:0] newByte
);
  logic sawFull, sawOvf;
  logic full, ovf;
  assign full = statusOut[7];
  assign ovf  = statusOut[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sawFull <= 1'b0;
      sawOvf  <= 1'b0;
    end else if (dataRd) begin
      sawFull <= 1'b0;
      sawOvf  <= 1'b0;
    end else if (statusRd) begin
      sawFull <= full;
      sawOvf  <= ovf;
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    byteDone && !full && !ovf |=> full && dataOut == $past(newByte));
  a_r3_clear_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(dataRd) && $past(sawFull));
  a_r4_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    byteDone && full |=> ovf && $stable(dataOut));
  a_r5_ovf_survives: assert property (@(posedge clk) disable iff (!rst_n)
    dataRd && ovf && !sawOvf |=> ovf);
  a_r6_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    byteDone && ovf && !full |=> !full && $stable(dataOut));
  a_r7_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> $past(dataRd) && $past(sawOvf));
  a_r8_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrq == (statusOut[7] & statusOut[0]));
  a_r9_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    errIrq == (statusOut[6] & statusOut[1]));
endmodule

bind spi_rx_flags spi_rx_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .statusRd(statusRd), .dataRd(dataRd),
  .statusOut(statusOut), .dataOut(dataOut), .rxIrq(rxIrq), .errIrq(errIrq),
  .byteDone(byteDone), .newByte(newByte)
);

// File: tb/spi_rx_flags_bench.sv
`timescale 1ns/1ps
module spi_rx_flags_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic statusRd = 1'b0, dataRd = 1'b0, ctrlWr = 1'b0;
  logic [1:0] ctrlWrData = 2'b00;
  logic [7:0] statusOut, dataOut;
  logic rxIrq, errIrq;
  int checks = 0, errors = 0;
  logic [7:0] st;

  always #5 clk = ~clk;

  spi_rx_flags u_spi_rx_flags (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ss_n(ss_n),
    .statusRd(statusRd), .dataRd(dataRd), .ctrlWr(ctrlWr),
    .ctrlWrData(ctrlWrData), .statusOut(statusOut), .dataOut(dataOut),
    .rxIrq(rxIrq), .errIrq(errIrq)
  );

  // vector: send, byte, statusRead, dataRead, expFull, expOvf, expData
  localparam int NV = 9;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5},  // R2 load
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5},  // R3 data read alone keeps full
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5},  // R3 status then data clears
    {1'b1, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C},  // R2 load again
    {1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C},  // R4 overflow keeps old
    {1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C},  // R6 lost during overflow
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C},  // R7 both cleared
    {1'b1, 8'h81, 1'b0, 1'b0, 1'b1, 1'b0, 8'h81},  // R2 after recovery
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81}   // R3 status read alone
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    ss_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic readStatus(output logic [7:0] v);
    @(negedge clk);
    statusRd = 1'b1;
    v = statusOut;
    @(negedge clk);
    statusRd = 1'b0;
  endtask

  task automatic readData();
    @(negedge clk);
    dataRd = 1'b1;
    @(negedge clk);
    dataRd = 1'b0;
  endtask

  task automatic writeCtrl(input logic [1:0] v);
    @(negedge clk);
    ctrlWr = 1'b1;
    ctrlWrData = v;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", statusOut, 8'h00);
    chk("R1 data", dataOut, 8'h00);
    chk("R1 irqs", {rxIrq, errIrq}, 2'b00);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][20]) sendBits(VEC[v][19:12], 8);
      if (VEC[v][11]) readStatus(st);
      if (VEC[v][10]) readData();
      @(negedge clk);
      chk($sformatf("R2-R7 vector %0d full", v), statusOut[7], VEC[v][9]);
      chk($sformatf("R2-R7 vector %0d ovf", v), statusOut[6], VEC[v][8]);
      chk($sformatf("R2-R7 vector %0d data", v), dataOut, VEC[v][7:0]);
    end

    // R5: overflow between status read and data read (full armed by last vector)
    readStatus(st);
    sendBits(8'h42, 8);
    readData();
    @(negedge clk);
    chk("R5 full cleared", statusOut[7], 1'b0);
    chk("R5 ovf kept", statusOut[6], 1'b1);
    chk("R5 data kept", dataOut, 8'h81);
    // R6: byte during overflow with full clear is lost
    sendBits(8'h99, 8);
    chk("R6 full stays clear", statusOut[7], 1'b0);
    chk("R6 data unchanged", dataOut, 8'h81);
    // R7: data read without status read leaves overflow
    readData();
    @(negedge clk);
    chk("R7 ovf not cleared", statusOut[6], 1'b1);
    readStatus(st);
    chk("R7 status sees ovf", st[6], 1'b1);
    readData();
    @(negedge clk);
    chk("R7 ovf cleared", statusOut[6], 1'b0);

    // R10: partial byte then select release
    sendBits(8'hFF, 3);
    chk("R10 no byte from partial", statusOut[7], 1'b0);
    sendBits(8'h5A, 8);
    chk("R10 aligned byte", dataOut, 8'h5A);

    // R11 / R8 / R9
    writeCtrl(2'b11);
    @(negedge clk);
    chk("R11 status readback", statusOut, 8'h83);
    chk("R8 rxIrq asserted", rxIrq, 1'b1);
    chk("R9 errIrq idle", errIrq, 1'b0);
    sendBits(8'h66, 8);
    chk("R9 errIrq on overflow", errIrq, 1'b1);
    writeCtrl(2'b01);
    @(negedge clk);
    chk("R9 errIrq masked", errIrq, 1'b0);
    chk("R11 enables", statusOut[1:0], 2'b01);
    writeCtrl(2'b00);
    @(negedge clk);
    chk("R8 rxIrq masked", rxIrq, 1'b0);
    chk("R11 flags kept", statusOut, 8'hC0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule